// File: doc/BRIEF.md
# Multi-Channel Phase-Delayed Toggle Timer

This block generates eight square waves from one 16-bit base timer. Each channel holds a 16-bit compare value. Whenever the running timer equals that value, the channel's output level flips. All channels watch the same timebase, so their outputs share one period and differ only in phase. Each channel's offset is set by its own compare value. Every match on an enabled channel also raises a sticky interrupt-request flag for that channel.

The base timer runs in one of two modes. In free-running mode it wraps through all 65536 values. In reset mode it restarts from zero after reaching channel 0's compare value n. In that mode the timer stays at n for one extra cycle before it clears, so each half-period lasts exactly n+2 clocks. The timer sequencer is a three-state machine:
- `TMR_STOP`: the timer is idle.
- `TMR_COUNT`: the timer counts, and matches are evaluated here.
- `TMR_HOLD`: the single extra cycle after the channel 0 match in reset mode.

The transitions are:
- STOP→COUNT when `count_en` is high.
- COUNT→STOP when `count_en` drops.
- COUNT→HOLD on the channel 0 match in reset mode.
- HOLD→COUNT, with the timer cleared to zero, when `count_en` is high.
- HOLD stays in HOLD, with the timer frozen, while `count_en` is low.

Top module: `phase_toggle_timer`

## Requirements
- R1: After reset, every `wave_out` bit is 0, every `irq_flag` bit is 0 and the base timer is 0.
- R2: In the cycle after a channel's `ch_en` bit rises, its output level equals its `ch_init` bit. After that, an enabled channel flips its level on each compare match.
- R3: In reset mode (`reset_mode`=1) with channel 0 compare value n, channel 0's output stays at each level for exactly n+2 clocks.
- R4: In free-running mode (`reset_mode`=0), a channel's output stays at each level for exactly 65536 clocks.
- R5: In reset mode, a channel k whose compare value is k ≤ n changes level exactly k+2 clocks after each change of channel 0.
- R6: In reset mode, a channel whose compare value is greater than n never changes level.
- R7: While a channel's `ch_en` bit is 0, its output level does not change and its `irq_flag` bit is not set, even when the timer passes its compare value.
- R8: A match on an enabled channel sets its `irq_flag` bit. The bit stays at 1 until a one-cycle `irq_clr` pulse clears it. If a set and a clear occur in the same cycle, the set wins.
- R9: `ch_inv`=1 inverts the channel's output pin combinationally, in the same cycle, without changing its stored level.
- R10: While `count_en` is 0, the base timer holds its value and no output changes level.
- R11: Channel j's compare value occupies bits [16j+15:16j] of `cmp_vals`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_en | input | 1 | Base timer count enable |
| reset_mode | input | 1 | 1: channel 0 match restarts the timer; 0: free-running |
| ch_en | input | 8 | Per-channel enable |
| ch_init | input | 8 | Per-channel starting level, loaded when enable rises |
| ch_inv | input | 8 | Per-channel output inversion |
| cmp_vals | input | 128 | Eight 16-bit compare values, channel j at [16j+15:16j] |
| irq_clr | input | 8 | Per-channel interrupt flag clear pulse |
| wave_out | output | 8 | Waveform outputs |
| irq_flag | output | 8 | Sticky interrupt-request flags |

## Verification
The main function is tried with a table of reset-mode settings that pair different n values (0, 1, 3, 9, 20) with a second channel's compare value. The channel 0 half-width separates the n+2 hold behaviour from a plain n+1 wrap. The second channel's delay after channel 0 tells a correct phase offset from an off-by-one. An entry whose compare value lies above n checks that such a channel is never reached.

A long free-running run checks the full 16-bit wrap. Directed sequences then cover:
- loading the starting level;
- inversion at the pin;
- a disabled channel passing its match;
- a frozen timer;
- a clear pulse landing in the same cycle as a set.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
    typedef enum logic [1:0] {
        TMR_STOP  = 2'd0,
        TMR_COUNT = 2'd1,
        TMR_HOLD  = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/ptt_base_timer.sv
module ptt_base_timer
    import ptt_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          count_en,
    input  logic          reset_mode,
    input  logic [TW-1:0] cmp0,
    output logic [TW-1:0] timer,
    output tmr_state_e    state,
    output logic          sample_ok
);
    tmr_state_e state_nx;
    logic       hit0;

    assign hit0 = (timer == cmp0);

    always_comb begin
        state_nx = state;
        unique case (state)
            TMR_STOP:  state_nx = count_en ? TMR_COUNT : TMR_STOP;
            TMR_COUNT: begin
                if (!count_en)               state_nx = TMR_STOP;
                else if (reset_mode && hit0) state_nx = TMR_HOLD;
                else                         state_nx = TMR_COUNT;
            end
            TMR_HOLD:  state_nx = count_en ? TMR_COUNT : TMR_HOLD;
            default:   state_nx = TMR_STOP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TMR_STOP;
        else        state <= state_nx;
    end

    // timer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer <= '0;
        end else if (count_en) begin
            if (state == TMR_HOLD)
                timer <= '0;
            else if (state == TMR_COUNT && state_nx == TMR_COUNT)
                timer <= timer + 1'b1;
        end
    end

    // outputs
    always_comb begin
        sample_ok = (state == TMR_COUNT) && count_en;
    end
endmodule

// File: rtl/ptt_channel.sv
module ptt_channel #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          init_lvl,
    input  logic          inv,
    input  logic [TW-1:0] cmp,
    input  logic [TW-1:0] timer,
    input  logic          sample_ok,
    input  logic          irq_clr,
    output logic          wave,
    output logic          irq
);
    logic en_q;
    logic lvl;
    logic hit;

    assign hit = sample_ok && en && (timer == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            lvl  <= 1'b0;
            irq  <= 1'b0;
        end else begin
            en_q <= en;
            if (en && !en_q) lvl <= init_lvl;
            else if (hit)    lvl <= ~lvl;
            if (hit)          irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
        end
    end

    assign wave = lvl ^ inv;
endmodule

// File: rtl/phase_toggle_timer.sv
module phase_toggle_timer
    import ptt_pkg::*;
#(
    parameter int NCH = 8,
    parameter int TW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic              reset_mode,
    input  logic [NCH-1:0]    ch_en,
    input  logic [NCH-1:0]    ch_init,
    input  logic [NCH-1:0]    ch_inv,
    input  logic [NCH*TW-1:0] cmp_vals,
    input  logic [NCH-1:0]    irq_clr,
    output logic [NCH-1:0]    wave_out,
    output logic [NCH-1:0]    irq_flag
);
    logic [TW-1:0] timer;
    tmr_state_e    tstate;
    logic          sample_ok;

    ptt_base_timer #(.TW(TW)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en   (count_en),
        .reset_mode (reset_mode),
        .cmp0       (cmp_vals[TW-1:0]),
        .timer      (timer),
        .state      (tstate),
        .sample_ok  (sample_ok)
    );

    for (genvar j = 0; j < NCH; j++) begin : g_ch
        ptt_channel #(.TW(TW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (ch_en[j]),
            .init_lvl  (ch_init[j]),
            .inv       (ch_inv[j]),
            .cmp       (cmp_vals[j*TW +: TW]),
            .timer     (timer),
            .sample_ok (sample_ok),
            .irq_clr   (irq_clr[j]),
            .wave      (wave_out[j]),
            .irq       (irq_flag[j])
        );
    end
endmodule

// File: rtl/ptt_checker.sv
module ptt_checker
    import ptt_pkg::*;
#(
    parameter int NCH = 8,
    parameter int TW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           count_en,
    input logic [NCH-1:0] ch_en,
    input logic [NCH-1:0] ch_inv,
    input logic [NCH-1:0] irq_clr,
    input logic [NCH-1:0] wave_out,
    input logic [NCH-1:0] irq_flag,
    input logic [TW-1:0]  timer,
    input tmr_state_e     tstate
);
    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> $stable(timer));

    assert_hold_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == TMR_HOLD && count_en) |=> (tstate == TMR_COUNT && timer == '0));

    for (genvar j = 0; j < NCH; j++) begin : g_chk
        assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_flag[j] && !irq_clr[j]) |=> irq_flag[j]);

        assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[j] |=> ((wave_out[j] ^ ch_inv[j]) == $past(wave_out[j] ^ ch_inv[j])));

        assert_disabled_noirq_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_en[j] && !irq_flag[j]) |=> !irq_flag[j]);

        assert_stopped_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!count_en && $past(ch_en[j]) && ch_en[j])
                |=> ((wave_out[j] ^ ch_inv[j]) == $past(wave_out[j] ^ ch_inv[j])));
    end
endmodule

bind phase_toggle_timer ptt_checker #(.NCH(NCH), .TW(TW)) u_ptt_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (count_en),
    .ch_en    (ch_en),
    .ch_inv   (ch_inv),
    .irq_clr  (irq_clr),
    .wave_out (wave_out),
    .irq_flag (irq_flag),
    .timer    (timer),
    .tstate   (tstate)
);

// File: tb/phase_toggle_timer_test.sv
`timescale 1ns/1ps
module phase_toggle_timer_test;
    localparam int NCH = 8;
    localparam int TW  = 16;
    localparam int NV  = 6;

    // each entry: {n (ch0 compare), k (channel index and its compare value)}
    localparam int VEC [NV][2] = '{
        '{0, 0}, '{1, 1}, '{3, 2}, '{9, 4}, '{20, 7}, '{5, 6}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              count_en = 1'b0;
    logic              reset_mode = 1'b0;
    logic [NCH-1:0]    ch_en = '0;
    logic [NCH-1:0]    ch_init = '0;
    logic [NCH-1:0]    ch_inv = '0;
    logic [NCH*TW-1:0] cmp_vals = '0;
    logic [NCH-1:0]    irq_clr = '0;
    logic [NCH-1:0]    wave_out;
    logic [NCH-1:0]    irq_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    phase_toggle_timer #(.NCH(NCH), .TW(TW)) uut (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        count_en = 1'b0; reset_mode = 1'b0; ch_en = '0; ch_init = '0;
        ch_inv = '0; cmp_vals = '0; irq_clr = '0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    // counts negedges until wave_out[ch] changes; -1 if limit reached
    task automatic wait_change(input int ch, input int limit, output int cnt);
        logic p;
        bit   seen;
        p = wave_out[ch];
        seen = 1'b0;
        cnt = 0;
        while (!seen && cnt < limit) begin
            @(negedge clk);
            cnt++;
            if (wave_out[ch] !== p) seen = 1'b1;
        end
        if (!seen) cnt = -1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c;
        // R1: reset state
        do_reset();
        @(negedge clk);
        check("R1 wave_out", int'(wave_out), 0);
        check("R1 irq_flag", int'(irq_flag), 0);

        // table of reset-mode vectors: R3, R5, R6, R11
        for (int v = 0; v < NV; v++) begin
            int n, k;
            n = VEC[v][0];
            k = VEC[v][1];
            do_reset();
            reset_mode = 1'b1;
            cmp_vals[0 +: TW] = TW'(n);
            cmp_vals[k*TW +: TW] = TW'(k);
            ch_en[0] = 1'b1;
            ch_en[k] = 1'b1;
            count_en = 1'b1;
            wait_change(0, 100, c);
            wait_change(0, 100, c);
            check($sformatf("R3 half width n=%0d", n), c, n + 2);
            wait_change(0, 100, c);
            check($sformatf("R3 half width again n=%0d", n), c, n + 2);
            if (k != 0) begin
                if (k <= n) begin
                    wait_change(k, 100, c);
                    check($sformatf("R5 R11 delay ch%0d after ch0 n=%0d", k, n), c, k + 2);
                end else begin
                    wait_change(k, 3 * (n + 2), c);
                    check($sformatf("R6 ch%0d beyond n=%0d", k, n), c, -1);
                end
            end
        end

        // R2 and R9: start level load and combinational invert
        do_reset();
        ch_init[2] = 1'b1;
        ch_en[2] = 1'b1;
        @(negedge clk);
        check("R2 start level", int'(wave_out[2]), 1);
        ch_inv[2] = 1'b1;
        #0.5;
        check("R9 invert same cycle", int'(wave_out[2]), 0);
        ch_inv[2] = 1'b0;
        #0.5;
        check("R9 invert release", int'(wave_out[2]), 1);

        // R10: frozen timer, no level change
        do_reset();
        reset_mode = 1'b1;
        cmp_vals[0 +: TW] = 16'd5;
        ch_en[0] = 1'b1;
        count_en = 1'b1;
        wait_change(0, 50, c);
        count_en = 1'b0;
        wait_change(0, 40, c);
        check("R10 no change while stopped", c, -1);
        count_en = 1'b1;
        wait_change(0, 50, c);
        check("R10 resumes", int'(c > 0), 1);

        // R8 and R7: set-wins over clear, clear alone, disabled channel
        do_reset();
        cmp_vals[1*TW +: TW] = 16'd3;
        cmp_vals[2*TW +: TW] = 16'd3;
        ch_en[1] = 1'b1;
        @(negedge clk);
        count_en = 1'b1;           // edge E1: STOP->COUNT, match at value v on edge E(v+2)
        repeat (4) @(negedge clk);
        check("R8 flag clear before match", int'(irq_flag[1]), 0);
        irq_clr[1] = 1'b1;         // same edge as the match on value 3 (E5)
        @(negedge clk);
        irq_clr[1] = 1'b0;
        check("R8 set wins over clear", int'(irq_flag[1]), 1);
        check("R2 toggled on match", int'(wave_out[1]), 1);
        check("R7 disabled no irq", int'(irq_flag[2]), 0);
        check("R7 disabled level held", int'(wave_out[2]), 0);
        repeat (5) @(negedge clk);
        check("R8 sticky", int'(irq_flag[1]), 1);
        irq_clr[1] = 1'b1;
        @(negedge clk);
        irq_clr[1] = 1'b0;
        check("R8 clear pulse", int'(irq_flag[1]), 0);

        // R4: free-running full wrap
        do_reset();
        cmp_vals[3*TW +: TW] = 16'd100;
        ch_en[3] = 1'b1;
        count_en = 1'b1;
        wait_change(3, 200, c);
        wait_change(3, 70000, c);
        check("R4 free-run half width", c, 65536);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule